// File: doc/BRIEF.md
# Decoded Memory-Mapped Bus Subsystem

This block sits behind a processor-style bus with a 16-bit address, an 8-bit data path and separate active-high read and write strobes. It turns each address into one target among five choices:

- two 1K x 8 RAM banks;
- a deliberately empty 1K window;
- a four-byte register file;
- a 4K x 8 read-only table;
- nothing at all, for addresses outside the decoded range.

It then performs the access on the selected target. A write lands on the rising clock edge. A read returns data combinationally while the read strobe is held.

The shared data bus is split into two ports: a write-data input and a read-data output. An output-enable flag says when the block would drive the bus. Whenever that flag is low, the read-data port carries 00h. The read-only table needs no initialisation file, because its contents are computed from the address. A one-cycle error flag reports the illegal case where both strobes are asserted on a decoded target.

Top module: `mem_subsys`

## Requirements
- R1: Only addresses with bits 15..13 all zero are decoded. For any other address, output-enable stays low, read data is 00h, and a write changes no storage.
- R2: Bit 12 set selects the read-only table, whatever bits 11..10 hold. With bit 12 clear, bits 11..10 pick the target: 0 is RAM bank 0, 1 is RAM bank 1, 2 is the empty window, 3 is the register file.
- R3: Each RAM bank holds 1024 bytes indexed by address bits 9..0. A write strobe stores write data at the rising clock edge. A read strobe returns the stored byte in the same cycle.
- R4: The register file holds four bytes indexed by address bits 1..0, so 0C04h to 0FFFh alias onto the same four bytes. All four bytes read 00h after reset.
- R5: The read-only table returns `addr[7:0] ^ {4'h0, addr[11:8]} ^ A5h`. A write decoded to it changes nothing.
- R6: Output-enable is high exactly when a readable target is selected with read=1 and write=0. When output-enable is low, read data is 00h.
- R7: With read and write asserted together, no storage is written and output-enable stays low.
- R8: The error flag is high for the one cycle after each clock edge at which both strobes were asserted with RAM, the register file or the table selected. In every other case it is low.
- R9: The empty window (bits 15..12 zero, bits 11..10 equal to 2) never raises output-enable, reads 00h, and a write there changes no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; stores and the error flag update on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data from the bus |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| rdata_o | output | 8 | Read data; 00h when not driving |
| oe_o | output | 1 | Bus drive enable |
| err_o | output | 1 | Strobe-conflict pulse |

## Verification
The assertions check the following on every cycle:
- output-enable never rises without a clean read strobe;
- output-enable stays low outside the decoded range and in the empty window;
- read data is 00h whenever output-enable is low;
- table reads match the address formula;
- the error flag follows a conflict on a decoded target, and only such a conflict.

Some behaviours depend on storage history, and only the bench's scenarios can show them:
- a write to RAM lands in the right bank at the right index;
- a blocked write (conflict, empty window, table, out of range) leaves earlier contents intact;
- register aliasing reaches the same byte.

The bench sweeps both RAM banks and the whole table exhaustively.

// File: rtl/mem_pkg.sv
package mem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_HOLE,
    RG_REGS,
    RG_ROM
  } region_e;
endpackage

// File: rtl/mem_decoder.sv
module mem_decoder
  import mem_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int ROM_AW = 12,
  localparam int SEL_W = ROM_AW - RAM_AW
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SEL_W-1:0]  bank_o
);
  localparam int NUM_RAM  = (1 << SEL_W) - 2;
  localparam int HOLE_IDX = NUM_RAM;
  localparam int REGS_IDX = NUM_RAM + 1;

  logic             enable;
  logic             rom_bit;
  logic [SEL_W-1:0] sel;

  assign enable  = (addr_i[ADDR_W-1:ROM_AW+1] == '0);
  assign rom_bit = addr_i[ROM_AW];
  assign sel     = addr_i[ROM_AW-1:RAM_AW];
  assign bank_o  = sel;

  always_comb begin
    region_o = RG_NONE;
    if (enable) begin
      if (rom_bit)                              region_o = RG_ROM;
      else if (int'(sel) == REGS_IDX)           region_o = RG_REGS;
      else if (int'(sel) == HOLE_IDX)           region_o = RG_HOLE;
      else                                      region_o = RG_RAM;
    end
  end
endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank
  import mem_pkg::*;
#(
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mem_reg_file.sv
module mem_reg_file
  import mem_pkg::*;
#(
  parameter int AW = 2,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[g] <= '0;
      else if (we_i && addr_i == AW'(g)) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/mem_rom.sv
module mem_rom
  import mem_pkg::*;
#(
  parameter int              AW  = 12,
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // Fold the index bits above the low byte into the low nibble.
  logic [DATA_W-1:0] fold;
  assign fold    = DATA_W'(addr_i[AW-1:DATA_W]);
  assign rdata_o = addr_i[DATA_W-1:0] ^ fold ^ KEY;
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
  import mem_pkg::*;
#(
  parameter int                RAM_AW  = 10,
  parameter int                ROM_AW  = 12,
  parameter int                REG_AW  = 2,
  parameter logic [DATA_W-1:0] ROM_KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o,
  output logic              oe_o,
  output logic              err_o
);
  localparam int SEL_W   = ROM_AW - RAM_AW;
  localparam int NUM_RAM = (1 << SEL_W) - 2;

  region_e           region;
  logic [SEL_W-1:0]  bank;
  logic              wr_ok, rd_ok, dev_sel, conflict;
  logic [NUM_RAM-1:0] ram_we;
  logic [DATA_W-1:0] ram_rd [NUM_RAM];
  logic [DATA_W-1:0] reg_rd, rom_rd, ram_mux;
  logic              err_q;

  mem_decoder #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) i_dec (
    .addr_i  (addr_i),
    .region_o(region),
    .bank_o  (bank)
  );

  assign wr_ok    = wr_i & ~rd_i;
  assign rd_ok    = rd_i & ~wr_i;
  assign dev_sel  = (region == RG_RAM) | (region == RG_REGS) | (region == RG_ROM);
  assign conflict = rd_i & wr_i & dev_sel;

  for (genvar g = 0; g < NUM_RAM; g++) begin : g_ram
    assign ram_we[g] = wr_ok && region == RG_RAM && bank == SEL_W'(g);
    mem_ram_bank #(.AW(RAM_AW)) i_bank (
      .clk_i  (clk_i),
      .we_i   (ram_we[g]),
      .addr_i (addr_i[RAM_AW-1:0]),
      .wdata_i(wdata_i),
      .rdata_o(ram_rd[g])
    );
  end

  mem_reg_file #(.AW(REG_AW)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ok && region == RG_REGS),
    .addr_i (addr_i[REG_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(reg_rd)
  );

  mem_rom #(.AW(ROM_AW), .KEY(ROM_KEY)) i_rom (
    .addr_i (addr_i[ROM_AW-1:0]),
    .rdata_o(rom_rd)
  );

  always_comb begin
    ram_mux = '0;
    for (int i = 0; i < NUM_RAM; i++)
      if (bank == SEL_W'(i)) ram_mux = ram_rd[i];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (region)
        RG_RAM:  rdata_o = ram_mux;
        RG_REGS: rdata_o = reg_rd;
        RG_ROM:  rdata_o = rom_rd;
        default: rdata_o = '0;
      endcase
    end
  end

  assign oe_o = rd_ok & dev_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= conflict;
  end
  assign err_o = err_q;
endmodule

// File: rtl/mem_subsys_chk.sv
module mem_subsys_chk #(
  parameter logic [7:0] ROM_KEY = 8'hA5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [7:0]  rdata_o,
  input logic        oe_o,
  input logic        err_o
);
  logic in_range, in_hole, decoded;
  assign in_range = (addr_i[15:13] == 3'b000);
  assign in_hole  = (addr_i[15:12] == 4'h0) && (addr_i[11:10] == 2'b10);
  assign decoded  = in_range && !in_hole;

  AST_OE_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> !oe_o); // R1
  AST_OE_CLEAN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> (rd_i && !wr_i && decoded)); // R6
  AST_QUIET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == 8'h00)); // R6
  AST_NO_DRIVE_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> !oe_o); // R7
  AST_HOLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hole |-> !oe_o); // R9
  AST_ROM_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && addr_i[15:12] == 4'h1) |->
      (rdata_o == (addr_i[7:0] ^ {4'h0, addr_i[11:8]} ^ ROM_KEY))); // R5
  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && decoded) |=> err_o); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_i && wr_i && decoded)) |=> !err_o); // R8
endmodule

bind mem_subsys mem_subsys_chk #(.ROM_KEY(ROM_KEY)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .rdata_o(rdata_o),
  .oe_o   (oe_o),
  .err_o  (err_o)
);

// File: tb/test_mem_subsys.sv
module test_mem_subsys;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        oe_o;
  logic        err_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  mem_subsys i_mem_subsys (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] ram_pat(logic [15:0] a, logic [7:0] seed);
    return a[7:0] ^ {a[9:8], a[11:10], 4'h0} ^ seed;
  endfunction

  function automatic logic [7:0] rom_val(logic [15:0] a);
    return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hA5;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr_i, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic do_read(string req, logic [15:0] a, logic exp_oe, logic [7:0] exp_d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1; wr_i = 1'b0;
    #1;
    check(req, {7'd0, oe_o}, {7'd0, exp_oe});
    check(req, rdata_o, exp_d);
    rd_i = 1'b0;
  endtask

  // Both strobes for one edge; returns after checking no drive and the error flag.
  task automatic do_conflict(string req, logic [15:0] a, logic exp_err);
    @(negedge clk_i);
    addr_i = a; wdata_i = 8'h5A; rd_i = 1'b1; wr_i = 1'b1;
    #1;
    check({req, " R7 oe"}, {7'd0, oe_o}, 8'd0);
    check({req, " R7 data"}, rdata_o, 8'd0);
    @(posedge clk_i); #1;
    rd_i = 1'b0; wr_i = 1'b0;
    check({req, " R8 err"}, {7'd0, err_o}, {7'd0, exp_err});
    @(posedge clk_i); #1;
    check({req, " R8 drop"}, {7'd0, err_o}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // Reset state
    check("R6 reset oe", {7'd0, oe_o}, 8'd0);
    check("R8 reset err", {7'd0, err_o}, 8'd0);
    for (int i = 0; i < 4; i++) do_read("R4 reset regs", 16'h0C00 + 16'(i), 1'b1, 8'h00);

    // R3 R2: fill both banks, then read back
    for (int a = 0; a < 2048; a++) do_write(16'(a), ram_pat(16'(a), 8'h3C));
    for (int a = 0; a < 2048; a++) do_read("R3 ram", 16'(a), 1'b1, ram_pat(16'(a), 8'h3C));

    // R6 no strobe: nothing driven
    @(negedge clk_i); addr_i = 16'h0123; #1;
    check("R6 idle oe", {7'd0, oe_o}, 8'd0);
    check("R6 idle data", rdata_o, 8'd0);

    // R9 hole: writes store nothing, reads silent
    do_write(16'h0810, 8'hEE);
    do_write(16'h0BFF, 8'hEE);
    do_read("R9 hole", 16'h0810, 1'b0, 8'h00);
    do_read("R9 hole", 16'h0BFF, 1'b0, 8'h00);
    do_read("R9 bank0 intact", 16'h0010, 1'b1, ram_pat(16'h0010, 8'h3C));
    do_read("R9 bank1 intact", 16'h07FF, 1'b1, ram_pat(16'h07FF, 8'h3C));

    // R1 out of range
    for (int k = 1; k < 8; k++) begin
      do_write({3'(k), 13'h0010}, 8'h99);
      do_read("R1 outside", {3'(k), 13'h0010}, 1'b0, 8'h00);
      do_read("R1 outside", {3'(k), 13'h1005}, 1'b0, 8'h00);
    end
    do_read("R1 ram intact", 16'h0010, 1'b1, ram_pat(16'h0010, 8'h3C));

    // R4 register file and aliasing
    for (int i = 0; i < 4; i++) do_write(16'h0C00 + 16'(i), 8'h10 + 8'(i));
    for (int a = 16'h0C00; a < 16'h1000; a += 61)
      do_read("R4 alias", 16'(a), 1'b1, 8'h10 + {6'd0, 2'(a)});
    do_write(16'h0C05, 8'hAB);
    do_read("R4 alias write", 16'h0C01, 1'b1, 8'hAB);
    do_write(16'h0FFF, 8'hCD);
    do_read("R4 alias write", 16'h0C03, 1'b1, 8'hCD);
    do_read("R4 neighbour", 16'h0C02, 1'b1, 8'h12);

    // R5 R2: full table sweep, bits 11..10 ignored for selection
    for (int a = 16'h1000; a < 16'h2000; a++) do_read("R5 rom", 16'(a), 1'b1, rom_val(16'(a)));
    do_write(16'h1234, 8'h00);
    do_read("R5 rom write ignored", 16'h1234, 1'b1, rom_val(16'h1234));
    do_read("R5 ram not hit by rom write", 16'h0234, 1'b1, ram_pat(16'h0234, 8'h3C));

    // R7 R8 conflicts
    do_conflict("ram0", 16'h0040, 1'b1);
    do_read("R7 ram0 unchanged", 16'h0040, 1'b1, ram_pat(16'h0040, 8'h3C));
    do_conflict("ram1", 16'h0441, 1'b1);
    do_read("R7 ram1 unchanged", 16'h0441, 1'b1, ram_pat(16'h0441, 8'h3C));
    do_conflict("regs", 16'h0C00, 1'b1);
    do_read("R7 regs unchanged", 16'h0C00, 1'b1, 8'h10);
    do_conflict("rom", 16'h1800, 1'b1);
    do_conflict("hole", 16'h0900, 1'b0);
    do_conflict("outside", 16'h4000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule